// File: doc/BRIEF.md
# Strided Interleaved Bank Address Generator

This block turns one strided vector access into a stream of per-element memory requests. A start handshake supplies a base word address, a stride and an element count. The block then walks the elements in order. Element `i` uses the word address `base + i*stride`, wrapping at the address width. Each request goes to one of 16 interleaved banks, chosen by the low address bits.

A bank that takes a request stays busy for a fixed number of cycles. The block keeps a countdown for every bank. It holds issue whenever the bank of the next element is still busy. Elements are never reordered, so the element rate depends on how the stride spreads addresses over the banks. The memory answers every request a fixed 12 cycles later on that bank's read-data lane. The block selects the right lane and presents the data in element order with a valid flag and the element number. A done pulse closes the access.

The start interface is valid/ready. `start_ready` is high only while the block is idle. A start offered while `start_ready` is low is not taken, and its fields are ignored. The element output has no back-pressure, because the memory cannot hold data back. A consumer must take every word in the cycle `elem_valid` is high. Bank requests also carry no ready, since the block itself tracks when each bank can accept again.

Top module: `strided_bank_agen`

## Requirements
- R1: The request for element i carries the word address base + i*stride modulo 2^16 on `bank_addr`. Requests leave in element order 0, 1, 2, and so on.
- R2: Each request raises exactly one bit of `bank_req`, the bit whose number equals `bank_addr[3:0]`. In cycles with no request, `bank_req` is all zero.
- R3: Element 0 is requested in the first cycle after the start is accepted, unless its bank is busy. A bank that accepted a request in cycle t is not requested again before cycle t+4. Each element issues in the first cycle that is both after the previous element's issue and free for its own bank.
- R4: The data of the element requested in cycle t appears in cycle t+12. In that cycle `elem_valid` is 1, `elem_data` is the word on that bank's lane of `bank_rdata` (bits 32*b+31 down to 32*b for bank b), and `elem_index` is i. In all other cycles `elem_valid` is 0.
- R5: With stride 1, and with any stride whose residue modulo 16 is odd, one element issues per cycle. With stride 16, or any stride that is a multiple of 16, one element issues every 4 cycles.
- R6: A `start_len` larger than 64 is treated as 64.
- R7: `done` is high for exactly one cycle. That cycle is the one after the last element's `elem_valid`. For a length of zero it is the cycle after the start is accepted, and no request is made.
- R8: `start_ready` is 1 when the block is idle. It goes to 0 from the cycle after a non-zero-length start is accepted and returns to 1 in the `done` cycle. A start offered while `start_ready` is 0 has no effect on the requests, the element output or `done`.
- R9: While `rst_n` is low, and right after it, the outputs are as follows. `bank_req` is zero, `elem_valid` and `done` are 0, and `start_ready` is 1. A reset in the middle of an access drops it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | A new access is offered |
| start_ready | output | 1 | Block idle; the offered access is taken on this edge |
| start_base | input | 16 | Word address of element 0 |
| start_stride | input | 16 | Address step between elements, two's complement |
| start_len | input | 7 | Element count, clamped to 64 |
| bank_req | output | 16 | One-hot request strobe, one bit per bank |
| bank_addr | output | 16 | Word address of the current request |
| bank_rdata | input | 512 | Read data, 32 bits per bank, valid 12 cycles after that bank's request |
| elem_valid | output | 1 | Element data present this cycle |
| elem_data | output | 32 | Element read data |
| elem_index | output | 6 | Element number of `elem_data` |
| done | output | 1 | One-cycle pulse after the last element |

## Verification
The access is driven with several strides, each of which puts a different pattern of bank conflicts before the issue logic:
- Unit and odd strides touch all 16 banks, so they must run at one element per cycle.
- A stride of 16, and a stride of 0, stay on one bank, which exposes the 4-cycle rest.
- A stride of 8 alternates two banks, which gives the pair-then-gap rhythm.
- A stride of 4 revisits a bank exactly when it becomes free, which catches an off-by-one in the busy window.

A negative stride that wraps through address zero, an oversized length, a zero length and a start offered while busy cover the remaining boundaries. A reset in the middle of an access shows that the access is dropped.

// File: rtl/agen_pkg.sv
`timescale 1ns/1ps
package agen_pkg;
  localparam int AGEN_ADDR_W   = 16;
  localparam int AGEN_DATA_W   = 32;
  localparam int AGEN_NBANK    = 16;
  localparam int AGEN_BUSY_CYC = 4;
  localparam int AGEN_LAT      = 12;
  localparam int AGEN_MAXVL    = 64;
endpackage

// File: rtl/agen_issue.sv
`timescale 1ns/1ps
module agen_issue #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 7,
  parameter int IDX_W  = 6,
  parameter int NBANK  = 16,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  len,
  input  logic [NBANK-1:0]  bank_busy,
  output logic              req_fire,
  output logic [BANK_W-1:0] req_bank,
  output logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  req_idx,
  output logic              req_last
);
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [LEN_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pending;

  assign pending  = (left_q != '0);
  assign req_bank = addr_q[BANK_W-1:0];
  assign req_addr = addr_q;
  assign req_idx  = idx_q;
  assign req_last = (left_q == LEN_W'(1));
  assign req_fire = pending && !bank_busy[req_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
      idx_q    <= '0;
    end else if (load) begin
      addr_q   <= base;
      stride_q <= stride;
      left_q   <= len;
      idx_q    <= '0;
    end else if (req_fire) begin
      addr_q   <= addr_q + stride_q;
      left_q   <= left_q - LEN_W'(1);
      idx_q    <= idx_q + IDX_W'(1);
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_last && !load) |=> (req_addr == $past(req_addr) + $past(stride_q))); // R1

  AST_NO_LOAD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !pending); // R8
endmodule

// File: rtl/agen_bank_busy.sv
`timescale 1ns/1ps
module agen_bank_busy #(
  parameter int NBANK    = 16,
  parameter int BUSY_CYC = 4,
  parameter int BANK_W   = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [BANK_W-1:0] req_bank,
  output logic [NBANK-1:0]  busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  for (genvar g = 0; g < NBANK; g++) begin : gen_bank
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit     = req_fire && (req_bank == BANK_W'(g));
    assign busy[g] = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q <= '0;
      else if (hit)
        cnt_q <= CNT_W'(BUSY_CYC - 1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end

    AST_BANK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cnt_q == '0)); // R3
  end
endmodule

// File: rtl/agen_return.sv
`timescale 1ns/1ps
module agen_return #(
  parameter int LAT    = 12,
  parameter int NBANK  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [BANK_W-1:0]       push_bank,
  input  logic [IDX_W-1:0]        push_idx,
  input  logic                    push_last,
  input  logic [NBANK*DATA_W-1:0] lane_data,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data,
  output logic [IDX_W-1:0]        out_idx,
  output logic                    out_last
);
  localparam int TAG_W = 2 + BANK_W + IDX_W;

  logic [TAG_W-1:0]  stage_q [LAT];
  logic [TAG_W-1:0]  head;
  logic [BANK_W-1:0] head_bank;
  logic [IDX_W-1:0]  next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= {push, push_last, push_bank, push_idx};
      for (int s = 1; s < LAT; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign head      = stage_q[LAT-1];
  assign out_valid = head[TAG_W-1];
  assign out_last  = head[TAG_W-2] && out_valid;
  assign head_bank = head[IDX_W +: BANK_W];
  assign out_idx   = head[IDX_W-1:0];
  assign out_data  = lane_data[head_bank*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      next_q <= '0;
    else if (out_valid)
      next_q <= out_last ? '0 : out_idx + IDX_W'(1);
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == next_q)); // R4
endmodule

// File: rtl/strided_bank_agen.sv
`timescale 1ns/1ps
module strided_bank_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W   = AGEN_ADDR_W,
  parameter int DATA_W   = AGEN_DATA_W,
  parameter int NBANK    = AGEN_NBANK,
  parameter int BUSY_CYC = AGEN_BUSY_CYC,
  parameter int LAT      = AGEN_LAT,
  parameter int MAXVL    = AGEN_MAXVL,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int LEN_W   = $clog2(MAXVL + 1),
  localparam int IDX_W   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid,
  output logic                    start_ready,
  input  logic [ADDR_W-1:0]       start_base,
  input  logic [ADDR_W-1:0]       start_stride,
  input  logic [LEN_W-1:0]        start_len,
  output logic [NBANK-1:0]        bank_req,
  output logic [ADDR_W-1:0]       bank_addr,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  output logic                    elem_valid,
  output logic [DATA_W-1:0]       elem_data,
  output logic [IDX_W-1:0]        elem_index,
  output logic                    done
);
  logic              accept, active_q, done_q;
  logic [LEN_W-1:0]  len_eff;
  logic [NBANK-1:0]  busy;
  logic              req_fire, req_last, ret_last;
  logic [BANK_W-1:0] req_bank;
  logic [IDX_W-1:0]  req_idx;

  assign start_ready = !active_q;
  assign accept      = start_valid && start_ready;
  assign len_eff     = (start_len > LEN_W'(MAXVL)) ? LEN_W'(MAXVL) : start_len;
  assign done        = done_q;

  agen_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .NBANK(NBANK)) u_issue (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(start_base), .stride(start_stride),
    .len(len_eff), .bank_busy(busy), .req_fire(req_fire), .req_bank(req_bank),
    .req_addr(bank_addr), .req_idx(req_idx), .req_last(req_last));

  agen_bank_busy #(.NBANK(NBANK), .BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_bank(req_bank), .busy(busy));

  agen_return #(.LAT(LAT), .NBANK(NBANK), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ret (
    .clk(clk), .rst_n(rst_n), .push(req_fire), .push_bank(req_bank), .push_idx(req_idx),
    .push_last(req_last), .lane_data(bank_rdata), .out_valid(elem_valid),
    .out_data(elem_data), .out_idx(elem_index), .out_last(ret_last));

  for (genvar g = 0; g < NBANK; g++) begin : gen_req
    assign bank_req[g] = req_fire && (req_bank == BANK_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= ret_last || (accept && (len_eff == '0));
      if (accept && (len_eff != '0))
        active_q <= 1'b1;
      else if (ret_last)
        active_q <= 1'b0;
    end
  end

  AST_ONEHOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req)); // R2

  AST_REQ_BANK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_req != '0) |-> bank_req[bank_addr[BANK_W-1:0]]); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> start_ready); // R7

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (bank_req == '0)); // R8
endmodule

// File: tb/strided_bank_agen_test.sv
`timescale 1ns/1ps
module strided_bank_agen_test;
  localparam int AW = 16, DW = 32, NB = 16, BUSY = 4, LAT = 12, MAXVL = 64;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] stride;
    logic [7:0]  len;
    logic [7:0]  done_at;   // cycle of done, counted from the accept edge
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0001, 8'd16,  8'd29},  // R5 unit stride
    '{16'h0005, 16'h0010, 8'd4,   8'd26},  // R5 same bank every time
    '{16'h0003, 16'h0002, 8'd16,  8'd29},  // eight banks, no stall
    '{16'h0000, 16'h0008, 8'd8,   8'd27},  // two banks alternate
    '{16'h0010, 16'hFFFF, 8'd20,  8'd33},  // R1 negative stride wraps
    '{16'h0007, 16'h0004, 8'd9,   8'd22},  // revisit exactly at free
    '{16'h0100, 16'h0001, 8'd100, 8'd77},  // R6 clamp
    '{16'h1234, 16'h0000, 8'd3,   8'd22},  // stride zero
    '{16'hBEEF, 16'h0001, 8'd0,   8'd1},   // R7 zero length
    '{16'h0002, 16'h0011, 8'd16,  8'd29},  // odd residue
    '{16'h0000, 16'h0018, 8'd6,   8'd23}   // residue 8
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic start_valid = 1'b0, start_ready;
  logic [AW-1:0] start_base = '0, start_stride = '0;
  logic [6:0] start_len = '0;
  logic [NB-1:0] bank_req;
  logic [AW-1:0] bank_addr;
  logic [NB*DW-1:0] bank_rdata;
  logic elem_valid, done;
  logic [DW-1:0] elem_data;
  logic [5:0] elem_index;

  strided_bank_agen uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_base(start_base), .start_stride(start_stride), .start_len(start_len),
    .bank_req(bank_req), .bank_addr(bank_addr), .bank_rdata(bank_rdata),
    .elem_valid(elem_valid), .elem_data(elem_data), .elem_index(elem_index), .done(done));

  function automatic logic [31:0] memfn(input logic [15:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  function automatic logic [3:0] onehot_idx(input logic [NB-1:0] v);
    logic [3:0] r = '0;
    for (int b = 0; b < NB; b++) if (v[b]) r = 4'(b);
    return r;
  endfunction

  // behavioural memory: answers each request LAT cycles later on the requested lane
  logic       ml_v [LAT];
  logic [3:0] ml_b [LAT];
  logic [AW-1:0] ml_a [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) ml_v[s] <= 1'b0;
    end else begin
      ml_v[0] <= (bank_req != '0);
      ml_b[0] <= onehot_idx(bank_req);
      ml_a[0] <= bank_addr;
      for (int s = 1; s < LAT; s++) begin
        ml_v[s] <= ml_v[s-1]; ml_b[s] <= ml_b[s-1]; ml_a[s] <= ml_a[s-1];
      end
    end
  end
  always_comb begin
    bank_rdata = '0;
    if (ml_v[LAT-1]) bank_rdata[ml_b[LAT-1]*DW +: DW] = memfn(ml_a[LAT-1]);
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int rt [MAXVL];
    logic [AW-1:0] ra [MAXVL];
    int free_t [NB];
    int n, t, j, e, last_req, n_elem;
    n = (v.len > MAXVL) ? MAXVL : int'(v.len);
    t = 0;
    for (int b = 0; b < NB; b++) free_t[b] = 0;
    for (int i = 0; i < n; i++) begin
      ra[i] = v.base + AW'(i) * v.stride;
      t = t + 1;
      if (free_t[ra[i][3:0]] > t) t = free_t[ra[i][3:0]];
      rt[i] = t;
      free_t[ra[i][3:0]] = t + BUSY;
    end
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1; start_base = v.base; start_stride = v.stride; start_len = v.len[6:0];
    @(posedge clk);
    j = 0; e = 0; last_req = 0; n_elem = 0;
    for (int k = 1; k <= int'(v.done_at); k++) begin
      @(negedge clk);
      if (j < n && rt[j] == k) begin
        chk(bank_req == NB'(1) << ra[j][3:0], "R2 R3 bank strobe", 64'(bank_req), 64'(NB'(1) << ra[j][3:0]));
        chk(bank_addr == ra[j], "R1 element address", 64'(bank_addr), 64'(ra[j]));
        last_req = k; j++;
      end else begin
        chk(bank_req == '0, "R3 no request", 64'(bank_req), 64'd0);
      end
      if (e < n && rt[e] + LAT == k) begin
        chk(elem_valid && elem_data == memfn(ra[e]) && elem_index == 6'(e), "R4 element data",
            {elem_valid, 7'd0, 18'd0, elem_index, elem_data}, {8'h80, 18'd0, 6'(e), memfn(ra[e])});
        e++; n_elem++;
      end else begin
        chk(!elem_valid, "R4 no element", 64'(elem_valid), 64'd0);
      end
      chk(done == (k == int'(v.done_at)), "R7 done pulse", 64'(done), 64'(k == int'(v.done_at)));
      if (n > 0 && (k == int'(v.done_at) || k == int'(v.done_at) - 1))
        chk(start_ready == (k == int'(v.done_at)), "R8 start_ready", 64'(start_ready), 64'(k == int'(v.done_at)));
      // offer a junk start while busy
      if (n > 0 && k <= int'(v.done_at) - 2) begin
        start_valid = 1'b1; start_base = 16'h7777; start_stride = 16'h0003; start_len = 7'd5;
      end else begin
        start_valid = 1'b0;
      end
    end
    start_valid = 1'b0;
    chk(n_elem == n, "R6 element count", 64'(n_elem), 64'(n));
    if (n > 0)
      chk(last_req == int'(v.done_at) - LAT - 1, "R5 issue rate", 64'(last_req), 64'(int'(v.done_at) - LAT - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(start_ready && bank_req == '0 && !elem_valid && !done, "R9 in reset",
        {start_ready, bank_req, elem_valid, done}, {1'b1, 16'd0, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    chk(start_ready && bank_req == '0 && !elem_valid && !done, "R9 after reset",
        {start_ready, bank_req, elem_valid, done}, {1'b1, 16'd0, 2'b00});

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // reset in the middle of an access
    @(negedge clk);
    start_valid = 1'b1; start_base = 16'h0040; start_stride = 16'h0001; start_len = 7'd16;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(start_ready && bank_req == '0 && !elem_valid && !done, "R9 mid-run reset",
        {start_ready, bank_req, elem_valid, done}, {1'b1, 16'd0, 2'b00});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(!elem_valid && !done && bank_req == '0, "R9 access dropped",
          {elem_valid, done, bank_req}, 64'd0);
    end
    run_vec(VECS[3]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule